// File: doc/BRIEF.md
# Multiplexed Program Memory Fetch Interface

This block fetches instruction bytes for a small core from an external program memory. The memory shares one 8-bit bus for two jobs. A phase line splits every instruction time into two halves of equal length. While the line is high, the core drives the low byte of the fetch address onto the bus. While it is low, the core releases the bus and the memory's tri-state output returns the instruction byte. The three upper address bits leave on dedicated outputs and are never multiplexed.

The block includes a model of the external demultiplex latch. That latch captures the low address byte when the phase line falls and holds it for the memory during the data half. The core presents an 11-bit address with a one-cycle request at any time. The latest request is fetched in the next instruction time. When no request arrives, the current address is fetched again. Every fetched byte comes back with a one-cycle valid pulse.

Top module: `pmem_fetch_mux`

## Requirements
- R1: While reset is held, `phase` is 1, `bus_oe` is 1, `bus_out` is 0, `addr_hi` is 0, `lat_addr` is 0 and `instr_valid` is 0.
- R2: Let k be the number of rising clock edges since reset was released, and pos = k mod INSTR_CLKS. `phase` is 1 for pos < INSTR_CLKS/2 and 0 otherwise. INSTR_CLKS is even and at least 4, and its default is 8.
- R3: `bus_oe` is 1 only for pos < INSTR_CLKS/2 - 1. It therefore drops one clock before `phase` falls and stays 0 for the whole data half. While `bus_oe` is 1, `bus_out` equals bits 7:0 of the address being fetched.
- R4: `addr_hi` equals bits 10:8 of the address being fetched. It changes only on the clock at which `phase` rises.
- R5: On the clock at which `phase` falls, `lat_addr` takes bits 7:0 of the address being fetched. It holds that value for the whole data half.
- R6: `instr_valid` is 1 for exactly one clock, at pos = 0 when k > 0. `instr_data` then holds the value of `bus_in` from the last clock of the preceding data half (pos = INSTR_CLKS-1).
- R7: After reset, no `instr_valid` appears before one full instruction time. The first pulse comes at k = INSTR_CLKS and carries the byte at address 0.
- R8: A request (`fetch_req` = 1 with `fetch_addr`) sampled at any pos of instruction time q is fetched in instruction time q+1, including a request at pos = INSTR_CLKS-1. The address of instruction time q is not disturbed. If several requests fall in one instruction time, the last one wins.
- R9: When no request arrives during an instruction time, the next instruction time fetches the same address again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_addr | input | 11 | Address to fetch, valid with fetch_req |
| fetch_req | input | 1 | One-cycle request from the core |
| phase | output | 1 | 1 = address half, 0 = data half |
| addr_hi | output | 3 | Dedicated upper address bits |
| bus_out | output | 8 | Shared bus value driven by the block |
| bus_oe | output | 1 | Output enable for bus_out |
| bus_in | input | 8 | Shared bus value read back from memory |
| lat_addr | output | 8 | Demultiplex latch output, low address byte |
| instr_data | output | 8 | Fetched instruction byte |
| instr_valid | output | 1 | One-cycle pulse marking a new instr_data |

## Verification
The boundary clock of an instruction time carries two jobs at once. On that clock the block samples the memory byte and raises valid for the ending fetch, and it also loads the next fetch address. The bench provokes this by placing a request exactly at pos = INSTR_CLKS-1, so it arrives on the same edge as the sample and the reload. The check is that the valid pulse still carries the byte from the old address, while the new address shows up on `addr_hi`, `bus_out` and `lat_addr` only in the following instruction time. The bench memory drives its real byte only on the last data clock, which also exposes a sample taken too early.

// File: rtl/pmem_fetch_mux.sv
module pmem_fetch_mux #(
  parameter int ADDR_W     = 11,
  parameter int BUS_W      = 8,
  parameter int INSTR_CLKS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              fetch_req,
  output logic              phase,
  output logic [ADDR_W-BUS_W-1:0] addr_hi,
  output logic [BUS_W-1:0]  bus_out,
  output logic              bus_oe,
  input  logic [BUS_W-1:0]  bus_in,
  output logic [BUS_W-1:0]  lat_addr,
  output logic [BUS_W-1:0]  instr_data,
  output logic              instr_valid
);
  localparam int HALF  = INSTR_CLKS / 2;
  localparam int CNT_W = $clog2(INSTR_CLKS);

  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] req_addr, cur_addr;
  logic [BUS_W-1:0]  lat_q, data_q;
  logic              valid_q;

  wire last  = (cnt == CNT_W'(INSTR_CLKS - 1));
  wire fall  = (cnt == CNT_W'(HALF - 1));
  wire [ADDR_W-1:0] next_addr = fetch_req ? fetch_addr : req_addr;

  initial assert (INSTR_CLKS >= 4 && INSTR_CLKS % 2 == 0)
    else $error("INSTR_CLKS must be even and >= 4");

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      req_addr <= '0;
      cur_addr <= '0;
      lat_q    <= '0;
      data_q   <= '0;
      valid_q  <= 1'b0;
    end else begin
      cnt     <= last ? '0 : cnt + 1'b1;
      valid_q <= last;
      if (fetch_req) req_addr <= fetch_addr;
      if (last) begin
        cur_addr <= next_addr;
        data_q   <= bus_in;
      end
      if (fall) lat_q <= cur_addr[BUS_W-1:0];
    end
  end

  assign phase       = (cnt < CNT_W'(HALF));
  assign bus_oe      = (cnt < CNT_W'(HALF - 1));
  assign bus_out     = bus_oe ? cur_addr[BUS_W-1:0] : '0;
  assign addr_hi     = cur_addr[ADDR_W-1:BUS_W];
  assign lat_addr    = lat_q;
  assign instr_data  = data_q;
  assign instr_valid = valid_q;

  // R3: the block never drives the bus in the data half
  p_oe_in_addr_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> phase);

  // R3: enable is already low on the clock before phase falls
  p_oe_low_before_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phase) |-> $past(!bus_oe));

  // R4: upper bits hold through the data half
  p_hi_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !phase |-> $stable(addr_hi));

  // R5: latched low byte holds through the data half
  p_lat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase && $past(!phase)) |-> $stable(lat_addr));

  // R6: valid is a single-clock pulse
  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid |=> !instr_valid);

  // R6: valid coincides with the return to the address half
  p_valid_on_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase) |-> instr_valid);
endmodule

// File: tb/pmem_fetch_mux_tb.sv
module pmem_fetch_mux_tb;
  localparam int N    = 8;
  localparam int HALF = N / 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] fetch_addr = '0;
  logic        fetch_req = 1'b0;
  logic        phase, bus_oe, instr_valid;
  logic [2:0]  addr_hi;
  logic [7:0]  bus_out, bus_in, lat_addr, instr_data;

  int checks = 0;
  int errors = 0;
  int e = 0;
  bit done = 0;
  logic [10:0] expq[$];
  logic [10:0] last_a = '0;

  always #2 clk = ~clk;

  pmem_fetch_mux #(.ADDR_W(11), .BUS_W(8), .INSTR_CLKS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr), .fetch_req(fetch_req),
    .phase(phase), .addr_hi(addr_hi), .bus_out(bus_out), .bus_oe(bus_oe),
    .bus_in(bus_in), .lat_addr(lat_addr), .instr_data(instr_data),
    .instr_valid(instr_valid));

  function automatic logic [7:0] memf(logic [10:0] a);
    return a[7:0] ^ {a[10:8], a[4:0]} ^ 8'h5C;
  endfunction

  // memory: real byte only once its access time has elapsed (last data clock)
  assign bus_in = (!bus_oe && !phase && (e % N == N - 1)) ? memf({addr_hi, lat_addr}) : 8'hA5;

  always @(posedge clk) if (rst_n) e <= e + 1;

  task automatic chk(bit ok, string rq, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at k=%0d: actual %0h expected %0h", rq, e, act, exp);
    end
  endtask

  // driver: request in instruction time q at position pos
  task automatic req_at(int q, int pos, logic [10:0] a, bit push);
    while (e != q * N + pos) @(negedge clk);
    fetch_addr = a;
    fetch_req  = 1'b1;
    if (push) begin expq.push_back(a); last_a = a; end
    @(negedge clk);
    fetch_req = 1'b0;
  endtask

  // driver: no request in instruction time q, same address expected again (R9)
  task automatic idle(int q);
    while (e != q * N) @(negedge clk);
    expq.push_back(last_a);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int pos;
      logic [10:0] ex;
      pos = e % N;
      chk(instr_valid == (pos == 0 && e > 0), "R6 R7 valid", instr_valid, (pos == 0 && e > 0));
      if (instr_valid && expq.size() > 0) begin
        ex = expq.pop_front();
        chk(instr_data == memf(ex), "R6 R8 R9 data", instr_data, memf(ex));
      end
      chk(phase == (pos < HALF), "R2 phase", phase, (pos < HALF));
      chk(bus_oe == (pos < HALF - 1), "R3 oe", bus_oe, (pos < HALF - 1));
      if (expq.size() > 0) begin
        ex = expq[0];
        if (bus_oe) chk(bus_out == ex[7:0], "R3 bus_out", bus_out, ex[7:0]);
        chk(addr_hi == ex[10:8], "R4 R8 addr_hi", addr_hi, ex[10:8]);
        if (pos >= HALF) chk(lat_addr == ex[7:0], "R5 lat_addr", lat_addr, ex[7:0]);
      end
    end
  end

  initial begin
    expq.push_back(11'h000);
    repeat (4) @(negedge clk);
    chk(phase == 1'b1, "R1 phase", phase, 1);
    chk(bus_oe == 1'b1, "R1 oe", bus_oe, 1);
    chk(bus_out == 8'h00, "R1 bus_out", bus_out, 0);
    chk(addr_hi == 3'd0, "R1 addr_hi", addr_hi, 0);
    chk(lat_addr == 8'h00, "R1 lat_addr", lat_addr, 0);
    chk(instr_valid == 1'b0, "R1 valid", instr_valid, 0);
    rst_n = 1'b1;
    idle(0);                          // R7: first fetch is address 0
    req_at(1, 0, 11'h123, 1);
    req_at(2, 2, 11'h7FF, 1);
    req_at(3, 5, 11'h400, 1);         // request in data half
    req_at(4, N - 1, 11'h0FF, 1);     // R8: request on the boundary clock
    idle(5);                          // R9
    req_at(6, 1, 11'h2AA, 0);
    req_at(6, 6, 11'h555, 1);         // R8: last request wins
    req_at(7, 3, 11'h000, 1);
    req_at(8, N - 1, 11'h7FE, 1);
    idle(9);
    while (e != 11 * N + 1) @(negedge clk);
    chk(expq.size() == 0, "R6 all fetches returned", expq.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule